// File: doc/BRIEF.md
# Multi-mode quadrature position counter

This block tracks the position of an incremental encoder. Two asynchronous pins, A and B, are synchronised into the system clock domain and passed through edge detectors. A mode decoder turns those edges into increment and decrement steps. It supports four count sources: x4 quadrature, pulse with direction, up-only and down-only. A register-held position counter applies the steps. The counter stays between zero and a programmable maximum and wraps at either end.

Software reaches five registers through a zero-wait-state memory-mapped port. The registers are the position, a load value, the maximum, a decoder control word and a control word. A one-cycle strobe copies the load value into the position. In quadrature mode, a sample in which both pins change at once counts as a phase error. It raises a sticky fault output.

Top module: `qpos_counter`

## Requirements
- R1: After reset, the position is 0, the load value is 0, the maximum reads all ones, both control words read 0 (counter disabled, quadrature source) and the phase fault is low.
- R2: With source field 0 (decoder control bits 15:14), every edge of A and of B is one step. When A leads B (AB sequence 00,10,11,01,00) the position rises by one per edge.
- R3: In quadrature mode, when B leads A (sequence 00,01,11,10,00) the position falls by one per edge.
- R4: In quadrature mode, a sample in which A and B both change gives no step and sets the phase fault. The fault stays set until reset.
- R5: With source field 1, only rising edges of A step. B high gives an increment and B low a decrement. Falling edges of A and edges of B do not step.
- R6: With source field 2, A steps upward and B has no effect. Decoder control bit 11 at 0 counts rising edges of A only. At 1 it counts both edges of A.
- R7: With source field 3, A steps downward under the same bit 11 edge rule, and B has no effect.
- R8: Control bit 3 enables counting. While it is 0 the position holds through any pin activity.
- R9: An increment from the maximum gives 0. A decrement from 0 gives the maximum.
- R10: A bus write to the position with a value above the current maximum leaves the position unchanged. A value at or below the maximum is stored.
- R11: The load strobe copies the load value into the position. A bus write to the position in the same cycle wins over the strobe, and either one wins over a step.
- R12: Byte offsets: position 0x00, load value 0x04, maximum 0x08, decoder control 0x28, control 0x2A. Reads are combinational. The 16-bit words return their defined bits in place and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Asynchronous encoder input A (also clock in pulse modes) |
| enc_b | input | 1 | Asynchronous encoder input B (also direction) |
| load_pulse | input | 1 | One-cycle strobe: copy load value into the position |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | Write enable for the selected register |
| reg_addr | input | ADDR_W (6) | Byte offset of the register |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data, combinational from reg_addr |
| pos_value | output | CW (32) | Current position |
| phase_fault | output | 1 | Sticky quadrature phase error flag |

## Verification
A wrong step decision shows up on pos_value three clock edges after the pin change that caused it: two synchroniser flops, then the counter register. A wrong direction, a missed edge or a spurious count leaves a fixed offset that stays visible at every later sample. A corrupted maximum or wrong wrap logic shows only when the position meets zero or the maximum, so the bench drives the counter across both ends. Mode and enable state can be read straight back on reg_rdata in the same cycle.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_POS  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_LOAD = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_MAX  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_DEC  = 6'h28;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 6'h2A;

  localparam int unsigned SRC_MSB  = 15;
  localparam int unsigned SRC_LSB  = 14;
  localparam int unsigned BOTH_BIT = 11;
  localparam int unsigned EN_BIT   = 3;

  typedef enum logic [1:0] {
    SRC_QUAD = 2'd0,
    SRC_DIR  = 2'd1,
    SRC_UP   = 2'd2,
    SRC_DOWN = 2'd3
  } src_mode_e;

endpackage

// File: rtl/qpos_sync_edge.sv
module qpos_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[LAST];
  end

  assign lvl  = chain[LAST];
  assign rise = chain[LAST] & ~prev;
  assign fall = ~chain[LAST] & prev;

  generate
    if (STAGES == 2) begin : g_chk
      // R2: a detected rising edge traces back to the pin two samples earlier
      assert_rise_from_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(pin, 2));
      assert_fall_from_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !$past(pin, 2));
    end
  endgenerate

endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  src_mode_e src,
  input  logic      both_a,
  input  logic      lvl_a,
  input  logic      lvl_b,
  input  logic      rise_a,
  input  logic      fall_a,
  input  logic      rise_b,
  input  logic      fall_b,
  output logic      step_up,
  output logic      step_dn,
  output logic      phase_bad
);

  logic edge_a, edge_b, pulse_hit;

  assign edge_a    = rise_a | fall_a;
  assign edge_b    = rise_b | fall_b;
  assign pulse_hit = rise_a | (both_a & fall_a);

  always_comb begin
    step_up   = 1'b0;
    step_dn   = 1'b0;
    phase_bad = 1'b0;
    case (src)
      SRC_QUAD: begin
        if (edge_a && edge_b) begin
          phase_bad = 1'b1;
        end else if (edge_a) begin
          step_up = (lvl_a != lvl_b);
          step_dn = (lvl_a == lvl_b);
        end else if (edge_b) begin
          step_up = (lvl_a == lvl_b);
          step_dn = (lvl_a != lvl_b);
        end
      end
      SRC_DIR: begin
        step_up = rise_a & lvl_b;
        step_dn = rise_a & ~lvl_b;
      end
      SRC_UP:   step_up = pulse_hit;
      SRC_DOWN: step_dn = pulse_hit;
      default: ;
    endcase
  end

  // R4: at most one of increment, decrement or phase error per cycle
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn, phase_bad}));
  // R6: pulse-count modes step only on an edge of A, whatever B does
  assert_b_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((src == SRC_UP || src == SRC_DOWN) && !rise_a && !fall_a) |-> (!step_up && !step_dn));
  // R5: direction mode never steps on a falling A
  assert_dir_rise_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_DIR && !rise_a) |-> (!step_up && !step_dn));

endmodule

// File: rtl/qpos_core.sv
module qpos_core #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] max_val,
  input  logic          step_up,
  input  logic          step_dn,
  input  logic          phase_bad,
  output logic [CW-1:0] pos,
  output logic          fault
);

  function automatic logic [CW-1:0] wrap_inc(input logic [CW-1:0] v, input logic [CW-1:0] top);
    return (v >= top) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [CW-1:0] wrap_dec(input logic [CW-1:0] v, input logic [CW-1:0] top);
    return (v == '0 || v > top) ? top : v - 1'b1;
  endfunction

  logic wr_ok;
  logic count_go;

  assign wr_ok    = wr_en && (wr_val <= max_val);
  assign count_go = en && !wr_ok && !load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (wr_ok) begin
      pos <= wr_val;
    end else if (load_en) begin
      pos <= load_val;
    end else if (count_go && step_up) begin
      pos <= wrap_inc(pos, max_val);
    end else if (count_go && step_dn) begin
      pos <= wrap_dec(pos, max_val);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fault <= 1'b0;
    else if (en && phase_bad)  fault <= 1'b1;
  end

  assert_wrap_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_go && step_up && pos == max_val) |=> (pos == '0));
  assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_go && step_dn && pos == '0) |=> (pos == $past(max_val)));
  assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en && !load_en) |=> $stable(pos));
  assert_reject_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_val > max_val && !load_en && !en) |=> $stable(pos));
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_val <= max_val) |=> (pos == $past(wr_val)));
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !wr_en) |=> (pos == $past(load_val)));
  assert_fault_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int unsigned   CW          = 32,
  parameter int unsigned   DW          = 32,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter logic [CW-1:0] MAX_RESET   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              load_pulse,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [CW-1:0]     pos_value,
  output logic              phase_fault
);

  localparam int unsigned NCH = 2;

  logic [NCH-1:0] pins, lvl, rise, fall;

  logic [CW-1:0] load_q, max_q;
  src_mode_e     src_q;
  logic          both_q;
  logic          en_q;

  logic wr_any, wr_pos;
  logic step_up, step_dn, phase_bad;

  assign pins = {enc_b, enc_a};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_in
    qpos_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins[ch]),
      .lvl  (lvl[ch]),
      .rise (rise[ch]),
      .fall (fall[ch])
    );
  end

  assign wr_any = reg_sel & reg_we;
  assign wr_pos = wr_any && (reg_addr == OFF_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      max_q  <= MAX_RESET;
      src_q  <= SRC_QUAD;
      both_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (wr_any) begin
      case (reg_addr)
        OFF_LOAD: load_q <= reg_wdata[CW-1:0];
        OFF_MAX:  max_q  <= reg_wdata[CW-1:0];
        OFF_DEC: begin
          src_q  <= src_mode_e'(reg_wdata[SRC_MSB:SRC_LSB]);
          both_q <= reg_wdata[BOTH_BIT];
        end
        OFF_CTL:  en_q <= reg_wdata[EN_BIT];
        default: ;
      endcase
    end
  end

  qpos_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src_q),
    .both_a   (both_q),
    .lvl_a    (lvl[0]),
    .lvl_b    (lvl[1]),
    .rise_a   (rise[0]),
    .fall_a   (fall[0]),
    .rise_b   (rise[1]),
    .fall_b   (fall[1]),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .phase_bad(phase_bad)
  );

  qpos_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .wr_en    (wr_pos),
    .wr_val   (reg_wdata[CW-1:0]),
    .load_en  (load_pulse),
    .load_val (load_q),
    .max_val  (max_q),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .phase_bad(phase_bad),
    .pos      (pos_value),
    .fault    (phase_fault)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_POS:  reg_rdata = DW'(pos_value);
      OFF_LOAD: reg_rdata = DW'(load_q);
      OFF_MAX:  reg_rdata = DW'(max_q);
      OFF_DEC: begin
        reg_rdata[SRC_MSB:SRC_LSB] = src_q;
        reg_rdata[BOTH_BIT]        = both_q;
      end
      OFF_CTL:  reg_rdata[EN_BIT] = en_q;
      default: ;
    endcase
  end

  // R12: the position register reads back the live position
  assert_pos_readback_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFF_POS) |-> (reg_rdata == DW'(pos_value)));
  // R8: with counting disabled and no bus or load activity, the position holds
  assert_top_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_any && !load_pulse) |=> $stable(pos_value));

endmodule

// File: tb/qpos_counter_test.sv
module qpos_counter_test;
  import qpos_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, load_pulse = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, pos_value;
  logic        phase_fault;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  qpos_counter uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .load_pulse(load_pulse),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pos_value(pos_value), .phase_fault(phase_fault)
  );

  // scoreboard item: kind 0 = position pin, 1 = read data, 2 = fault flag
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sbq[$];

  logic [31:0] model_pos = 0;
  logic [31:0] model_max = 32'hFFFF_FFFF;

  function automatic logic [31:0] mod_up(logic [31:0] v, logic [31:0] m);
    logic [63:0] r;
    r = (64'(v) + 64'd1) % (64'(m) + 64'd1);
    return r[31:0];
  endfunction

  function automatic logic [31:0] mod_dn(logic [31:0] v, logic [31:0] m);
    logic [63:0] r;
    r = (64'(v) + 64'(m)) % (64'(m) + 64'd1);
    return r[31:0];
  endfunction

  task automatic expect_item(int kind, logic [31:0] exp, string req);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sbq.push_back(it);
    wait (sbq.size() == 0);
    #1;
  endtask

  // monitor: pops each expected item and compares with the design outputs
  initial begin
    forever begin
      sb_item_t it;
      logic [31:0] act;
      wait (sbq.size() > 0);
      #1;
      it = sbq[0];
      case (it.kind)
        0:       act = pos_value;
        1:       act = reg_rdata;
        default: act = {31'd0, phase_fault};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
      end
      void'(sbq.pop_front());
    end
  end

  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic check_read(logic [5:0] a, logic [31:0] e, string req);
    @(negedge clk);
    reg_addr = a;
    expect_item(1, e, req);
  endtask

  task automatic set_ab(logic a, logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (5) @(negedge clk);
  endtask

  task automatic step_check(logic a, logic b, int dir, string req);
    set_ab(a, b);
    if (dir > 0)      model_pos = mod_up(model_pos, model_max);
    else if (dir < 0) model_pos = mod_dn(model_pos, model_max);
    expect_item(0, model_pos, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_item(0, 32'd0, "R1 position");
    expect_item(2, 32'd0, "R1 fault");
    check_read(OFF_MAX, 32'hFFFF_FFFF, "R1 max");
    check_read(OFF_CTL, 32'd0, "R1 control");
    check_read(OFF_DEC, 32'd0, "R1 decoder");
    check_read(OFF_LOAD, 32'd0, "R1 load");

    // R12 register map
    bus_write(OFF_MAX, 32'd1000); model_max = 1000;
    bus_write(OFF_LOAD, 32'd500);
    check_read(OFF_MAX, 32'd1000, "R12 max readback");
    check_read(OFF_LOAD, 32'd500, "R12 load readback");

    // R11 load strobe
    @(negedge clk); load_pulse = 1'b1;
    @(negedge clk); load_pulse = 1'b0;
    model_pos = 500;
    expect_item(0, model_pos, "R11 load strobe");

    bus_write(OFF_CTL, 32'h0000_0008);
    check_read(OFF_CTL, 32'h0000_0008, "R12 control readback");

    // R2 quadrature, A leads B
    for (int k = 0; k < 2; k++) begin
      step_check(1'b1, 1'b0, 1, "R2 quad up");
      step_check(1'b1, 1'b1, 1, "R2 quad up");
      step_check(1'b0, 1'b1, 1, "R2 quad up");
      step_check(1'b0, 1'b0, 1, "R2 quad up");
    end
    // R3 quadrature, B leads A
    step_check(1'b0, 1'b1, -1, "R3 quad down");
    step_check(1'b1, 1'b1, -1, "R3 quad down");
    step_check(1'b1, 1'b0, -1, "R3 quad down");
    step_check(1'b0, 1'b0, -1, "R3 quad down");

    // R4 phase error
    step_check(1'b1, 1'b1, 0, "R4 both change no count");
    expect_item(2, 32'd1, "R4 fault set");
    step_check(1'b0, 1'b1, 1, "R4 count resumes");
    step_check(1'b0, 1'b0, 1, "R4 count resumes");
    expect_item(2, 32'd1, "R4 fault sticky");

    // R8 disable holds
    bus_write(OFF_CTL, 32'd0);
    step_check(1'b1, 1'b0, 0, "R8 disabled hold");
    step_check(1'b1, 1'b1, 0, "R8 disabled hold");
    step_check(1'b0, 1'b0, 0, "R8 disabled hold");
    bus_write(OFF_CTL, 32'h0000_0008);

    // R5 pulse with direction
    bus_write(OFF_DEC, 32'h0000_4000);
    check_read(OFF_DEC, 32'h0000_4000, "R12 decoder readback");
    step_check(1'b0, 1'b1, 0, "R5 B edge no count");
    step_check(1'b1, 1'b1, 1, "R5 rise A with B high");
    step_check(1'b0, 1'b1, 0, "R5 fall A no count");
    step_check(1'b0, 1'b0, 0, "R5 B edge no count");
    step_check(1'b1, 1'b0, -1, "R5 rise A with B low");
    step_check(1'b0, 1'b0, 0, "R5 fall A no count");

    // R6 up count, rising only then both edges
    bus_write(OFF_DEC, 32'h0000_8000);
    step_check(1'b1, 1'b0, 1, "R6 up rise");
    step_check(1'b0, 1'b0, 0, "R6 up fall ignored");
    step_check(1'b0, 1'b1, 0, "R6 B ignored");
    step_check(1'b0, 1'b0, 0, "R6 B ignored");
    bus_write(OFF_DEC, 32'h0000_8800);
    step_check(1'b1, 1'b0, 1, "R6 both edges rise");
    step_check(1'b0, 1'b0, 1, "R6 both edges fall");

    // R7 down count
    bus_write(OFF_DEC, 32'h0000_C000);
    step_check(1'b1, 1'b0, -1, "R7 down rise");
    step_check(1'b0, 1'b0, 0, "R7 down fall ignored");
    step_check(1'b0, 1'b1, 0, "R7 B ignored");
    step_check(1'b0, 1'b0, 0, "R7 B ignored");

    // R9 wrap both ways
    bus_write(OFF_MAX, 32'd9); model_max = 9;
    bus_write(OFF_POS, 32'd9); model_pos = 9;
    expect_item(0, 32'd9, "R10 write at max accepted");
    bus_write(OFF_DEC, 32'h0000_8800);
    step_check(1'b1, 1'b0, 1, "R9 wrap max to zero");
    expect_item(0, 32'd0, "R9 value zero");
    bus_write(OFF_DEC, 32'h0000_C800);
    step_check(1'b0, 1'b0, -1, "R9 wrap zero to max");
    expect_item(0, 32'd9, "R9 value max");

    // R10 writes above max ignored
    bus_write(OFF_POS, 32'd12);
    expect_item(0, 32'd9, "R10 write above max ignored");
    bus_write(OFF_POS, 32'd3); model_pos = 3;
    expect_item(0, 32'd3, "R10 write in range");
    check_read(OFF_POS, 32'd3, "R12 position readback");

    // R11 priority: bus write beats load strobe in the same cycle
    bus_write(OFF_LOAD, 32'd4);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = OFF_POS; reg_wdata = 32'd2; load_pulse = 1'b1;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0; load_pulse = 1'b0;
    expect_item(0, 32'd2, "R11 write beats load");
    @(negedge clk); load_pulse = 1'b1;
    @(negedge clk); load_pulse = 1'b0;
    expect_item(0, 32'd4, "R11 load alone");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule